// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C/SMBus target that exposes a small bank of 16-bit registers to a bus master through an 8-bit pointer. SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer and a glitch filter. Edge logic then reports START (including repeated START), STOP, and SCL rising and falling edges. The target answers one 7-bit device address. It acknowledges by pulling SDA low on `sda_pull`, and the pad logic outside the block turns that into an open-drain drive.

A write always carries the pointer byte first. It can stop there, which only sets the pointer. It can also carry exactly two data bytes, high byte first, and these are handed to the user logic as one 16-bit write strobe. The pointer stays unchanged across transactions. A bare read (address with R/W=1) therefore returns the register that was selected last. To read a different register, the master writes the pointer and then issues a repeated START with a read address.

Register values come from the user logic on a flat parallel bus. Each register can be read-only, write-only or read/write:
- A write to a read-only register, or to a pointer beyond the bank, is acknowledged and then dropped.
- A read of a write-only register, or of a pointer beyond the bank, returns 0000h.

The controller states are:

| State | Role |
|---|---|
| ST_IDLE | Bus free |
| ST_ADDR | Shifting in the address byte |
| ST_ADDR_ACK | Driving the ACK for the address |
| ST_PTR | Shifting in the pointer byte |
| ST_PTR_ACK | Driving the ACK for the pointer |
| ST_DHI | Shifting in the high data byte |
| ST_DHI_ACK | Driving the ACK for the high byte |
| ST_DLO | Shifting in the low data byte |
| ST_DLO_ACK | Driving the ACK for the low byte |
| ST_TX | Sending a byte |
| ST_TX_ACK | Sampling the master's ACK |
| ST_SKIP | Bus busy, target not addressed or finished |

The transitions are:
- STOP goes to ST_IDLE from any state.
- START goes to ST_ADDR from any state.
- ST_ADDR goes to ST_ADDR_ACK on an address match after 8 bits, or to ST_SKIP otherwise.
- On the SCL falling edge, ST_ADDR_ACK goes to ST_TX for a read or ST_PTR for a write.
- Write path: ST_PTR → ST_PTR_ACK → ST_DHI → ST_DHI_ACK → ST_DLO → ST_DLO_ACK → ST_SKIP.
- ST_TX goes to ST_TX_ACK after 8 bits.
- ST_TX_ACK goes to ST_TX when the master ACKs, or to ST_SKIP when it NACKs.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset the pointer is 00h, so a bare read returns register 0, and `sda_pull` and `wr_en` are low.
- R2: Only an address byte whose upper 7 bits equal DEV_ADDR is acknowledged. Any other address is NACKed, and the target stays silent until the next START or STOP.
- R3: A write of only the pointer byte sets the pointer. The pointer then persists across later transactions, and every bare read returns that register until the pointer is written again.
- R4: A write of the pointer plus two data bytes gives one single-cycle `wr_en` pulse. On that pulse `wr_addr` is the pointer and `wr_data` is {first byte, second byte}, each byte received MSB first.
- R5: A pointer write followed by a repeated START and address+R returns the newly selected register, high byte then low byte, MSB first.
- R6: After each byte sent, a master ACK (SDA low) continues the read. The byte after the low byte is the high byte of the same register again. A master NACK (SDA high) ends the transfer, and SDA is released.
- R7: A write to a read-only register (bit set in RO_MASK) is acknowledged on every byte but produces no `wr_en`.
- R8: A read of a write-only register (bit set in WO_MASK), or of a pointer at or beyond NREG, returns 0000h. A write to a pointer at or beyond NREG produces no `wr_en`.
- R9: A third data byte in a write is NACKed and produces no second write strobe.
- R10: An SCL pulse shorter than FILT_LEN system clock cycles is ignored and does not count as a bit.
- R11: A STOP returns the target to idle and releases SDA. A write cut short by a STOP before its second data byte produces no `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_rd_bus | input | NREG*16 | Current value of every register; register i is at bits [16i+15:16i] |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Pointer value of the register being written |
| wr_data | output | 16 | Value to write, high byte first on the bus |

## Verification
Bus-condition detection and byte handling can fall in the same cycle. When a START or STOP is seen, the target may be partway through a byte or holding an ACK, and the bus condition must take priority over the pending byte.

The bench provokes this in three ways:
- A STOP sent right after the high data byte of a write.
- A repeated START sent right after a pointer byte, while the target is waiting for data.
- A STOP sent right after a NACKed read byte.

It judges the outcome at the ports. The write strobe count must not move. The data read after the repeated START must belong to the new pointer. `sda_pull` must be low once the bus is free.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DHI,
        ST_DHI_ACK,
        ST_DLO,
        ST_DLO_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned PTR_W  = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic          sync_a;
    logic          sync_b;
    logic [CW-1:0] stable_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= line_in;
            sync_b <= sync_a;
        end
    end

    // Output follows the synchronized line only after it has differed
    // from the output for FILT_LEN consecutive cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_cnt <= '0;
            line_out   <= 1'b1;
        end else if (sync_b != line_out) begin
            if (stable_cnt == CNT_LAST) begin
                stable_cnt <= '0;
                line_out   <= sync_b;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end else begin
            stable_cnt <= '0;
        end
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        start_ev = scl_f & scl_p & sda_p & ~sda_f;
        stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
        scl_rise = scl_f & ~scl_p;
        scl_fall = ~scl_f & scl_p;
    end

endmodule

// File: rtl/i2c_reg_view.sv
module i2c_reg_view
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter logic [NREG-1:0] RO_MASK = '0,
    parameter logic [NREG-1:0] WO_MASK = '0
) (
    input  logic [PTR_W-1:0]       ptr,
    input  logic [NREG*WORD_W-1:0] reg_rd_bus,
    output logic [WORD_W-1:0]      rd_value,
    output logic                   wr_allowed
);
    localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [PTR_W-1:0] NREG_P = PTR_W'(NREG);

    logic [WORD_W-1:0] visible [NREG];
    logic [NREG-1:0]   writable;
    logic              in_bank;
    logic [IDX_W-1:0]  idx;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign visible[g]  = WO_MASK[g] ? '0 : reg_rd_bus[g*WORD_W +: WORD_W];
        assign writable[g] = ~RO_MASK[g];
    end

    always_comb begin
        in_bank    = (ptr < NREG_P);
        idx        = ptr[IDX_W-1:0];
        rd_value   = in_bank ? visible[idx] : '0;
        wr_allowed = in_bank & writable[idx];
    end

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A,
    parameter int unsigned NREG = 8,
    parameter int unsigned FILT_LEN = 3,
    parameter logic [NREG-1:0] RO_MASK = NREG'(2'b11),
    parameter logic [NREG-1:0] WO_MASK = NREG'(3'b100)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_pull,
    input  logic [NREG*WORD_W-1:0] reg_rd_bus,
    output logic                   wr_en,
    output logic [PTR_W-1:0]       wr_addr,
    output logic [WORD_W-1:0]      wr_data
);
    localparam int unsigned NLINES = 2;

    tgt_state_e state_q;
    tgt_state_e state_d;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic              scl_f;
    logic              sda_f;
    logic              start_ev;
    logic              stop_ev;
    logic              scl_rise;
    logic              scl_fall;

    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [PTR_W-1:0]  ptr_q;
    logic              is_read;
    logic [7:0]        hi_q;
    logic [WORD_W-1:0] rd_word;
    logic [7:0]        tx_sh;
    logic              lo_sel;
    logic              mack;

    logic [WORD_W-1:0] view_value;
    logic              view_wr_ok;
    logic              byte_done;
    logic              addr_hit;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[g]),
            .line_out (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_reg_view #(
        .NREG    (NREG),
        .RO_MASK (RO_MASK),
        .WO_MASK (WO_MASK)
    ) u_view (
        .ptr        (ptr_q),
        .reg_rd_bus (reg_rd_bus),
        .rd_value   (view_value),
        .wr_allowed (view_wr_ok)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_d = is_read ? ST_TX : ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) state_d = ST_DHI;
                ST_DHI:      if (byte_done) state_d = ST_DHI_ACK;
                ST_DHI_ACK:  if (scl_fall) state_d = ST_DLO;
                ST_DLO:      if (byte_done) state_d = ST_DLO_ACK;
                ST_DLO_ACK:  if (scl_fall) state_d = ST_SKIP;
                ST_TX:       if (scl_fall && bitcnt == 4'd7) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = mack ? ST_TX : ST_SKIP;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            ptr_q    <= '0;
            is_read  <= 1'b0;
            hi_q     <= '0;
            rd_word  <= '0;
            tx_sh    <= '0;
            lo_sel   <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_ev || start_ev) begin
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_PTR, ST_DHI, ST_DLO: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            unique case (state_q)
                                ST_ADDR: begin
                                    is_read  <= shreg[0];
                                    sda_pull <= addr_hit;
                                end
                                ST_PTR: begin
                                    ptr_q    <= shreg;
                                    sda_pull <= 1'b1;
                                end
                                ST_DHI: begin
                                    hi_q     <= shreg;
                                    sda_pull <= 1'b1;
                                end
                                default: begin
                                    wr_en    <= view_wr_ok;
                                    wr_addr  <= ptr_q;
                                    wr_data  <= {hi_q, shreg};
                                    sda_pull <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                rd_word  <= view_value;
                                tx_sh    <= view_value[15:8];
                                lo_sel   <= 1'b0;
                                sda_pull <= ~view_value[15];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_DHI_ACK, ST_DLO_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                bitcnt   <= '0;
                            end else begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                sda_pull <= ~tx_sh[6];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_f;
                        end else if (scl_fall && mack) begin
                            lo_sel   <= ~lo_sel;
                            tx_sh    <= lo_sel ? rd_word[15:8] : rd_word[7:0];
                            sda_pull <= lo_sel ? ~rd_word[15] : ~rd_word[7];
                            bitcnt   <= '0;
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter logic [NREG-1:0] RO_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input tgt_state_e       state_q,
    input logic             scl_f,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             sda_pull,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_addr
);
    localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    // R11: STOP frees the bus side of the target
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE) && !sda_pull);

    // R5: a (repeated) START restarts address reception
    p_start_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (state_q == ST_ADDR));

    // R4: write strobe lasts a single cycle
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R7, R8: strobes only reach writable in-bank registers
    p_wr_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((int'(wr_addr) < NREG) && !RO_MASK[wr_addr[IDX_W-1:0]]));

    // R6: target starts pulling SDA only while SCL is low
    p_drive_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_f);

    // R2: no drive while idle or not addressed
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) || (state_q == ST_SKIP)) |-> !sda_pull);

endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(
    .NREG    (NREG),
    .RO_MASK (RO_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .scl_f    (scl_f),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
);

// File: tb/i2c_ptr_target_bench.sv
module i2c_ptr_target_bench;
    localparam int NREG = 8;
    localparam int Q    = 16;
    localparam logic [6:0] ADDR = 7'h1A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [NREG*16-1:0] reg_bus;
    logic wr_en;
    logic [7:0] wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    logic [7:0]  last_addr = '0;
    logic [15:0] last_data = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    function automatic logic [15:0] exp_reg(input int i);
        return 16'hA050 + 16'(i) * 16'h0111;
    endfunction

    initial begin
        for (int i = 0; i < NREG; i++) reg_bus[i*16 +: 16] = exp_reg(i);
    end

    i2c_ptr_target #(.DEV_ADDR(ADDR), .NREG(NREG), .FILT_LEN(3),
                     .RO_MASK(8'b0000_0011), .WO_MASK(8'b0000_0100)) u_i2c_ptr_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .reg_rd_bus(reg_bus),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    always @(negedge clk) begin
        if (wr_en) begin
            wr_cnt++;
            last_addr = wr_addr;
            last_data = wr_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = ~give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    // pointer-only write
    task automatic set_ptr(input logic [7:0] p, output logic a0, output logic a1);
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(p, a1);
        bus_stop();
    endtask

    // bare read of two bytes, NACK on the last
    task automatic bare_read(output logic ack, output logic [15:0] w);
        logic [7:0] h, l;
        bus_start();
        wr_byte({ADDR, 1'b1}, ack);
        rd_byte(1'b1, h);
        rd_byte(1'b0, l);
        bus_stop();
        w = {h, l};
    endtask

    task automatic t_reset();
        check("R1 sda_pull at reset", 32'(sda_pull), 0);
        check("R1 wr_en at reset", 32'(wr_en), 0);
    endtask

    task automatic t_reset_ptr();
        logic a; logic [15:0] w;
        bare_read(a, w);
        check("R1 read ack", 32'(a), 1);
        check("R1 reg0 via reset pointer", 32'(w), 32'(exp_reg(0)));
    endtask

    task automatic t_ptr_persist();
        logic a0, a1, a; logic [15:0] w;
        set_ptr(8'h03, a0, a1);
        check("R3 pointer acks", 32'({a0, a1}), 32'b11);
        bare_read(a, w);
        check("R3 first bare read", 32'(w), 32'(exp_reg(3)));
        bare_read(a, w);
        check("R3 second bare read", 32'(w), 32'(exp_reg(3)));
    endtask

    task automatic t_write();
        logic a0, a1, a2, a3; int c0;
        c0 = wr_cnt;
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h04, a1);
        wr_byte(8'hBE, a2);
        wr_byte(8'hEF, a3);
        bus_stop();
        check("R4 acks", 32'({a0, a1, a2, a3}), 32'hF);
        check("R4 one strobe", 32'(wr_cnt - c0), 1);
        check("R4 wr_addr", 32'(last_addr), 32'h04);
        check("R4 wr_data", 32'(last_data), 32'hBEEF);
    endtask

    task automatic t_rstart_read();
        logic a0, a1, a2; logic [7:0] h, l; int c0;
        c0 = wr_cnt;
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h05, a1);
        bus_rstart();
        wr_byte({ADDR, 1'b1}, a2);
        rd_byte(1'b1, h);
        rd_byte(1'b0, l);
        bus_stop();
        check("R5 acks", 32'({a0, a1, a2}), 32'h7);
        check("R5 data after repeated START", 32'({h, l}), 32'(exp_reg(5)));
        check("R5 no strobe from pointer-only part", 32'(wr_cnt - c0), 0);
    endtask

    task automatic t_wrap();
        logic a; logic [7:0] b0, b1, b2, b3;
        set_ptr(8'h06, a, a);
        bus_start();
        wr_byte({ADDR, 1'b1}, a);
        rd_byte(1'b1, b0);
        rd_byte(1'b1, b1);
        rd_byte(1'b1, b2);
        rd_byte(1'b0, b3);
        check("R6 wrap to high byte", 32'({b0, b1, b2, b3}),
              32'({exp_reg(6), exp_reg(6)}));
        check("R6 SDA released after NACK", 32'(sda_pull), 0);
        bus_stop();
    endtask

    task automatic t_read_only();
        logic a0, a1, a2, a3; int c0;
        c0 = wr_cnt;
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h01, a1);
        wr_byte(8'h12, a2);
        wr_byte(8'h34, a3);
        bus_stop();
        check("R7 read-only write acked", 32'({a0, a1, a2, a3}), 32'hF);
        check("R7 read-only write dropped", 32'(wr_cnt - c0), 0);
    endtask

    task automatic t_zero_reads();
        logic a, a0, a1, a2, a3; logic [15:0] w; int c0;
        set_ptr(8'h02, a, a);
        bare_read(a, w);
        check("R8 write-only reads zero", 32'(w), 0);
        set_ptr(8'h40, a, a);
        bare_read(a, w);
        check("R8 out-of-bank reads zero", 32'(w), 0);
        c0 = wr_cnt;
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h40, a1);
        wr_byte(8'h55, a2);
        wr_byte(8'h66, a3);
        bus_stop();
        check("R8 out-of-bank write dropped", 32'(wr_cnt - c0), 0);
    endtask

    task automatic t_third_byte();
        logic a0, a1, a2, a3, a4; int c0;
        c0 = wr_cnt;
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h07, a1);
        wr_byte(8'h0A, a2);
        wr_byte(8'h0B, a3);
        wr_byte(8'h0C, a4);
        bus_stop();
        check("R9 third data byte NACKed", 32'(a4), 0);
        check("R9 single strobe", 32'(wr_cnt - c0), 1);
        check("R9 strobe data", 32'({last_addr, last_data}), 32'h07_0A0B);
    endtask

    task automatic t_bad_addr();
        logic a0; int c0;
        c0 = wr_cnt;
        bus_start();
        wr_byte({7'h2B, 1'b0}, a0);
        wr_byte(8'h04, a0);
        wr_byte(8'h11, a0);
        wr_byte(8'h22, a0);
        bus_stop();
        check("R2 foreign address NACK", 32'(a0), 0);
        check("R2 foreign write no strobe", 32'(wr_cnt - c0), 0);
    endtask

    task automatic t_glitch();
        logic a0, a1, a; logic [15:0] w;
        bus_start();
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(Q);
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h03, a1);
        bus_stop();
        check("R10 acks despite SCL glitch", 32'({a0, a1}), 32'b11);
        bare_read(a, w);
        check("R10 pointer intact", 32'(w), 32'(exp_reg(3)));
    endtask

    task automatic t_stop_abort();
        logic a0, a1, a2; int c0;
        c0 = wr_cnt;
        bus_start();
        wr_byte({ADDR, 1'b0}, a0);
        wr_byte(8'h05, a1);
        wr_byte(8'h99, a2);
        bus_stop();
        check("R11 no strobe on cut write", 32'(wr_cnt - c0), 0);
        check("R11 SDA released after STOP", 32'(sda_pull), 0);
    endtask

    initial begin
        wq(5);
        t_reset();
        rst_n = 1'b1;
        wq(10);
        t_reset_ptr();
        t_ptr_persist();
        t_write();
        t_rstart_read();
        t_wrap();
        t_read_only();
        t_zero_reads();
        t_third_byte();
        t_bad_addr();
        t_glitch();
        t_stop_abort();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule